// File: doc/BRIEF.md
# Periodic Strobe Generator with Selectable Counter Encoding

The block emits a one-cycle high strobe on `tick` once in every sixteen clock cycles, forever, with no gap between periods. A free-running modulo-16 state machine drives it, and the strobe is decoded from that machine's final state. The encoding of the state register is chosen at elaboration time by the `ENCODING` parameter. The choices are plain binary (4 bits), reflected Gray code (4 bits) and a rotating one-hot ring (16 bits). The pulse timing is the same for all three.

The block is meant for side-by-side comparison of register switching activity. For that reason the raw state register is brought out on `state_dbg`, zero-extended to sixteen bits, so an observer can count how many flip-flops change on each step. The reset input is asynchronous and active low. Its release is passed through a two-stage synchronizer before it reaches the counter.

Top module: `periodic_strobe`

## Requirements
- R1: `tick` is high for exactly one cycle and low for the fifteen cycles between strobes, repeating without a gap. The step index k counts clock edges taken while the synchronized reset is released, modulo 16, starting at k = 0. `tick` is high exactly when k = 15.
- R2: While `rst_n` is low, `tick` is low and `state_dbg` holds its reset value: 0 for binary and Gray, 16'h0001 for one-hot. After `rst_n` rises, the state stays at its reset value through two more rising clock edges and steps on the third.
- R3: With `ENCODING = ENC_BIN` (value 0), `state_dbg[3:0]` equals k and `state_dbg[15:4]` is zero. The number of toggling bits on each step is the popcount of (k-1) XOR k.
- R4: With `ENCODING = ENC_GRAY` (value 1), `state_dbg[3:0]` equals k XOR (k >> 1), giving the sequence 0000, 0001, 0011, 0010, 0110, … 1001, 1000 and then back to 0000. The upper bits are zero. Exactly one bit changes on every step, including the wrap from 1000 to 0000.
- R5: With `ENCODING = ENC_ONEHOT` (value 2), `state_dbg` equals 1 << k. Exactly one bit is set, the pattern rotates left by one place per step, and exactly two bits change on every step.
- R6: For the same clock and reset, the three encodings produce `tick` on exactly the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| tick | output | 1 | One-cycle strobe, high on the last step of each 16-step period |
| state_dbg | output | 16 | Raw state register, zero-extended, for observing toggles |

## Verification
The assertions assume that the reset seen by the counter is released only on a clock edge. The internal synchronizer guarantees this for any timing of `rst_n`, so the checker is disabled on the synchronized reset and not on the raw pin. The stimulus has no data inputs to constrain. It varies only the reset: reset pulses of random length are inserted at random points, and one directed pulse lands exactly on the strobe cycle. This exercises reset at every phase of the count, including mid-period and on the terminal state.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  // State encoding of the period counter
  typedef enum logic [1:0] {
    ENC_BIN    = 2'd0,
    ENC_GRAY   = 2'd1,
    ENC_ONEHOT = 2'd2
  } enc_e;
endpackage

// File: rtl/strobe_rst_sync.sv
module strobe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/strobe_bin_ctr.sv
module strobe_bin_ctr #(
  parameter  int STEPS = 16,
  localparam int CW    = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] state,
  output logic          last
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_end;

  always_comb begin
    at_end = (cnt_q == CW'(STEPS - 1));
    cnt_d  = at_end ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign state = cnt_q;
  assign last  = at_end;
endmodule

// File: rtl/strobe_gray_ctr.sv
module strobe_gray_ctr #(
  parameter  int STEPS = 16,
  localparam int CW    = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] state,
  output logic          last
);
  logic [CW-1:0] g_q;
  logic [CW-1:0] g_d;
  logic [CW-1:0] b_cur;
  logic [CW-1:0] b_nxt;
  logic          at_end;

  function automatic logic [CW-1:0] to_bin(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    b_cur  = to_bin(g_q);
    at_end = (b_cur == CW'(STEPS - 1));
    b_nxt  = at_end ? '0 : b_cur + CW'(1);
    g_d    = b_nxt ^ (b_nxt >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  g_q <= '0;
    else if (en) g_q <= g_d;
  end

  assign state = g_q;
  assign last  = at_end;
endmodule

// File: rtl/strobe_onehot_ctr.sv
module strobe_onehot_ctr #(
  parameter int STEPS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [STEPS-1:0] state,
  output logic             last
);
  logic [STEPS-1:0] ring_q;
  logic [STEPS-1:0] ring_d;

  always_comb begin
    ring_d = {ring_q[STEPS-2:0], ring_q[STEPS-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ring_q <= STEPS'(1);
    else if (en) ring_q <= ring_d;
  end

  assign state = ring_q;
  assign last  = ring_q[STEPS-1];
endmodule

// File: rtl/periodic_strobe.sv
module periodic_strobe
  import strobe_pkg::*;
#(
  parameter enc_e ENCODING    = ENC_BIN,
  parameter int   STEPS       = 16,
  parameter int   SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick,
  output logic [STEPS-1:0] state_dbg
);
  localparam int CW = $clog2(STEPS);

  logic rst_sync_n;
  logic step_en;
  logic last_w;

  assign step_en = 1'b1;

  strobe_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  generate
    if (ENCODING == ENC_ONEHOT) begin : g_onehot
      logic [STEPS-1:0] st_w;
      strobe_onehot_ctr #(.STEPS(STEPS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (step_en),
        .state (st_w),
        .last  (last_w)
      );
      assign state_dbg = st_w;
    end else if (ENCODING == ENC_GRAY) begin : g_gray
      logic [CW-1:0] st_w;
      strobe_gray_ctr #(.STEPS(STEPS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (step_en),
        .state (st_w),
        .last  (last_w)
      );
      assign state_dbg = STEPS'(st_w);
    end else begin : g_bin
      logic [CW-1:0] st_w;
      strobe_bin_ctr #(.STEPS(STEPS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .en    (step_en),
        .state (st_w),
        .last  (last_w)
      );
      assign state_dbg = STEPS'(st_w);
    end
  endgenerate

  assign tick = last_w;
endmodule

// File: rtl/periodic_strobe_chk.sv
module periodic_strobe_chk
  import strobe_pkg::*;
#(
  parameter enc_e ENCODING = ENC_BIN,
  parameter int   STEPS    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [STEPS-1:0] state_dbg
);
  localparam int CW = $clog2(STEPS);

  logic [CW:0] gap_q;
  logic        armed_q;

  // cycles since the last strobe (or since reset release)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      gap_q   <= tick ? '0 : gap_q + (CW+1)'(1);
      armed_q <= 1'b1;
    end
  end

  a_r1_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == (CW+1)'(STEPS - 1)));

  a_r1_no_missed_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == (CW+1)'(STEPS - 1)) |-> tick);

  a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  generate
    if (ENCODING == ENC_GRAY) begin : g_gray
      a_r4_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ($countones(state_dbg ^ $past(state_dbg)) == 1));
    end else if (ENCODING == ENC_ONEHOT) begin : g_onehot
      a_r5_single_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_dbg) == 1);
      a_r5_two_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> ($countones(state_dbg ^ $past(state_dbg)) == 2));
    end else begin : g_bin
      a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (state_dbg[CW-1:0] ==
          (($past(state_dbg[CW-1:0]) == CW'(STEPS - 1)) ? CW'(0)
                                                        : $past(state_dbg[CW-1:0]) + CW'(1))));
    end
  endgenerate
endmodule

bind periodic_strobe periodic_strobe_chk #(
  .ENCODING (ENCODING),
  .STEPS    (STEPS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick      (tick),
  .state_dbg (state_dbg)
);

// File: tb/test_periodic_strobe.sv
module test_periodic_strobe;
  import strobe_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 16;
  localparam int N_CYCLES   = 3000;

  logic             clk;
  logic             rst_n;
  logic             tick_b, tick_g, tick_o;
  logic [STEPS-1:0] st_b, st_g, st_o;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 0;

  periodic_strobe #(.ENCODING(ENC_BIN), .STEPS(STEPS)) i_periodic_strobe (
    .clk(clk), .rst_n(rst_n), .tick(tick_b), .state_dbg(st_b));
  periodic_strobe #(.ENCODING(ENC_GRAY), .STEPS(STEPS)) i_periodic_strobe_gray (
    .clk(clk), .rst_n(rst_n), .tick(tick_g), .state_dbg(st_g));
  periodic_strobe #(.ENCODING(ENC_ONEHOT), .STEPS(STEPS)) i_periodic_strobe_onehot (
    .clk(clk), .rst_n(rst_n), .tick(tick_o), .state_dbg(st_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_bin(input int k);
    return 16'(k);
  endfunction
  function automatic logic [15:0] exp_gray(input int k);
    return 16'(k ^ (k >> 1));
  endfunction
  function automatic logic [15:0] exp_oh(input int k);
    return 16'(1) << k;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int  k    = 0;
    bit  s1   = 0;
    bit  s2   = 0;
    bit  adv  = 0;
    int  hold = 0;
    bit  dir_done = 0;
    int  prev_k = 0;
    logic [15:0] pb, pg, po;
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    hold  = 3;
    pb = '0; pg = '0; po = '0;
    for (int it = 0; it < N_CYCLES; it++) begin
      @(negedge clk);
      // R2: reset values while the pin is low
      if (!rst_n) begin
        check(tick_b == 1'b0 && tick_g == 1'b0 && tick_o == 1'b0, "R2", "tick in reset",
              {13'd0, tick_b, tick_g, tick_o}, 16'h0000);
        check(st_b == 16'h0000, "R2", "bin reset state", st_b, 16'h0000);
        check(st_g == 16'h0000, "R2", "gray reset state", st_g, 16'h0000);
        check(st_o == 16'h0001, "R2", "onehot reset state", st_o, 16'h0001);
      end
      // R1: strobe exactly on step 15
      check(tick_b == (k == 15), "R1", "binary tick", {15'd0, tick_b}, {15'd0, k == 15});
      // R6: all encodings agree
      check(tick_g == tick_b && tick_o == tick_b, "R6", "tick agreement",
            {13'd0, tick_b, tick_g, tick_o}, {13'd0, {3{k == 15}}});
      // R3, R4, R5: state values
      check(st_b == exp_bin(k), "R3", "binary state", st_b, exp_bin(k));
      check(st_g == exp_gray(k), "R4", "gray state", st_g, exp_gray(k));
      check(st_o == exp_oh(k), "R5", "onehot state", st_o, exp_oh(k));
      // toggle counts on every advancing step
      if (adv) begin
        check($countones(st_b ^ pb) == $countones(prev_k ^ k), "R3", "binary toggles",
              16'($countones(st_b ^ pb)), 16'($countones(prev_k ^ k)));
        check($countones(st_g ^ pg) == 1, "R4", "gray toggles",
              16'($countones(st_g ^ pg)), 16'd1);
        check($countones(st_o ^ po) == 2, "R5", "onehot toggles",
              16'($countones(st_o ^ po)), 16'd2);
      end
      pb = st_b; pg = st_g; po = st_o; prev_k = k;

      // choose reset for the next cycle
      if (hold > 0) begin
        hold--;
        rst_n = 1'b0;
      end else if (!dir_done && it > 400 && k == 15) begin
        // directed: reset lands on the strobe cycle
        dir_done = 1;
        hold = 1;
        rst_n = 1'b0;
      end else if ($urandom_range(0, 149) == 0) begin
        hold = int'($urandom_range(0, 3));
        rst_n = 1'b0;
      end else begin
        rst_n = 1'b1;
      end

      // model of the coming rising edge (two-stage release)
      if (!rst_n) begin
        s1 = 0; s2 = 0; k = 0; adv = 0;
      end else begin
        adv = s2;
        k   = s2 ? (k + 1) % STEPS : 0;
        s2  = s1;
        s1  = 1;
      end
    end
    summary();
  end
endmodule